// File: doc/BRIEF.md
# Tail-Cancelling Dual-Threshold Pulse Discriminator

This block sits behind one photomultiplier channel and takes a free-running stream of unsigned ADC samples. A fast pulse on such a channel decays slowly, and its exponential tail adds to every sample that follows. The block removes that residue by subtracting fifteen sixteenths of the previous accepted sample from the current one. What remains is the amplitude that arrived during the current clock alone.

The corrected amplitude is signed and one bit wider than the sample. It leaves the block together with two single-clock flags. Each flag compares the amplitude against its own programmable threshold, one high and one low. A flag rises only when the amplitude strictly exceeds its threshold. Neither flag can rise after reset until software lowers a threshold, because both thresholds reset to their largest value. Samples arrive with a valid strobe. Cycles without the strobe do not advance the history, and they produce an empty output slot.

Top module: `pulse_deconv_disc`

## Requirements
- R1: While reset is held and right after it is released, `amp_valid`, `flag_hi`, `flag_lo` and `amp_out` are all 0.
- R2: For an accepted sample A whose previous accepted sample was P, `amp_out` equals A − (P − floor(P/16)) as a signed value of width SAMPLE_W+1.
- R3: A sample accepted at rising edge E produces its result on the outputs just after edge E+2. `amp_valid` is high for exactly that one cycle.
- R4: The first accepted sample after reset produces no result. `amp_valid` and both flags stay 0 in its output slot.
- R5: A cycle with `smp_valid` low does not change the history, whatever `smp_data` holds. The next accepted sample is corrected against the last accepted one, and the idle cycle's output slot has `amp_valid` at 0.
- R6: `flag_hi` is 1 exactly when `amp_valid` is 1 and `amp_out` is strictly greater than the high threshold.
- R7: `flag_lo` is 1 exactly when `amp_valid` is 1 and `amp_out` is strictly greater than the low threshold.
- R8: A negative `amp_out` never raises either flag, even with both thresholds at 0.
- R9: A write with `thr_wr_en` high loads `thr_wr_data` into the high threshold when `thr_wr_sel` is 1 and into the low threshold when it is 0. The new value is used for every comparison made after the write edge.
- R10: After reset both thresholds equal 2^SAMPLE_W − 1, so even the largest possible amplitude of 1023 raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | High when `smp_data` holds a new sample |
| smp_data | input | SAMPLE_W | Unsigned ADC sample |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_sel | input | 1 | 1 selects the high threshold, 0 selects the low threshold |
| thr_wr_data | input | SAMPLE_W | Threshold value to write |
| amp_out | output | SAMPLE_W+1 | Signed tail-corrected amplitude |
| amp_valid | output | 1 | `amp_out` holds a result this cycle |
| flag_hi | output | 1 | Amplitude exceeds the high threshold |
| flag_lo | output | 1 | Amplitude exceeds the low threshold |

## Verification
A step from 0 to full scale gives the largest positive amplitude, which shows that the reset thresholds hold both flags off. A large sample followed by a small one drives the amplitude negative while both thresholds are 0, which separates the sign handling from the comparison. A valid sample, a run of idle cycles carrying garbage data and then another sample show whether the history advances only on accepted samples. A long random stream with about one quarter idle cycles, mixed with occasional threshold rewrites, covers the arithmetic and the strict comparison at many operating points.

// File: rtl/pulse_deconv_disc.sv
module pulse_deconv_disc #(
  parameter int SAMPLE_W    = 10,
  parameter int DECAY_SHIFT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp_valid,
  input  logic [SAMPLE_W-1:0]   smp_data,
  input  logic                  thr_wr_en,
  input  logic                  thr_wr_sel,
  input  logic [SAMPLE_W-1:0]   thr_wr_data,
  output logic signed [SAMPLE_W:0] amp_out,
  output logic                  amp_valid,
  output logic                  flag_hi,
  output logic                  flag_lo
);

  localparam logic [SAMPLE_W-1:0] THR_MAX = '1;

  logic [SAMPLE_W-1:0] cur_q, prev_q;
  logic                seen_q, s1_v;
  logic signed [SAMPLE_W:0] delta_q;
  logic                d_v;
  logic [SAMPLE_W-1:0] thr_hi_q, thr_lo_q;

  wire [SAMPLE_W-1:0] decay = prev_q - (prev_q >> DECAY_SHIFT);
  wire signed [SAMPLE_W:0] delta = $signed({1'b0, cur_q}) - $signed({1'b0, decay});
  wire signed [SAMPLE_W:0] thr_hi_s = $signed({1'b0, thr_hi_q});
  wire signed [SAMPLE_W:0] thr_lo_s = $signed({1'b0, thr_lo_q});
  wire pos = !delta_q[SAMPLE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
      seen_q <= 1'b0;
      s1_v   <= 1'b0;
    end else begin
      s1_v <= smp_valid && seen_q;
      if (smp_valid) begin
        cur_q  <= smp_data;
        prev_q <= cur_q;
        seen_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      delta_q <= '0;
      d_v     <= 1'b0;
    end else begin
      d_v <= s1_v;
      if (s1_v) delta_q <= delta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_hi_q <= THR_MAX;
      thr_lo_q <= THR_MAX;
    end else if (thr_wr_en) begin
      if (thr_wr_sel) thr_hi_q <= thr_wr_data;
      else            thr_lo_q <= thr_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      amp_out   <= '0;
      amp_valid <= 1'b0;
      flag_hi   <= 1'b0;
      flag_lo   <= 1'b0;
    end else begin
      amp_valid <= d_v;
      amp_out   <= d_v ? delta_q : '0;
      flag_hi   <= d_v && pos && (delta_q > thr_hi_s);
      flag_lo   <= d_v && pos && (delta_q > thr_lo_s);
    end
  end

endmodule

// File: rtl/pdd_checker.sv
module pdd_checker #(
  parameter int SAMPLE_W = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     smp_valid,
  input logic signed [SAMPLE_W:0] amp_out,
  input logic                     amp_valid,
  input logic                     flag_hi,
  input logic                     flag_lo,
  input logic [SAMPLE_W-1:0]      thr_hi,
  input logic [SAMPLE_W-1:0]      thr_lo
);

  AST_NEG_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_valid && amp_out < 0) |-> (!flag_hi && !flag_lo)); // R8

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    amp_valid |-> $past(smp_valid, 3)); // R3

  AST_HI_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    flag_hi |-> (amp_valid && amp_out > $signed({1'b0, $past(thr_hi)}))); // R6

  AST_HI_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_valid && amp_out > $signed({1'b0, $past(thr_hi)})) |-> flag_hi); // R6

  AST_LO_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    flag_lo |-> (amp_valid && amp_out > $signed({1'b0, $past(thr_lo)}))); // R7

  AST_LO_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    (amp_valid && amp_out > $signed({1'b0, $past(thr_lo)})) |-> flag_lo); // R7

endmodule

bind pulse_deconv_disc pdd_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .amp_out(amp_out),
  .amp_valid(amp_valid), .flag_hi(flag_hi), .flag_lo(flag_lo),
  .thr_hi(thr_hi_q), .thr_lo(thr_lo_q)
);

// File: tb/sim_pulse_deconv_disc.sv
module sim_pulse_deconv_disc;
  localparam int SW = 10;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, thr_wr_en = 0, thr_wr_sel = 0;
  logic [SW-1:0] smp_data = '0, thr_wr_data = '0;
  logic signed [SW:0] amp_out;
  logic amp_valid, flag_hi, flag_lo;

  int tests = 0, fails = 0;
  int seen = 0, prev = 0, thr_hi_m = 1023, thr_lo_m = 1023;
  int e_v[3], e_a[3], e_h[3], e_l[3];
  string ctx = "R2";

  always #4 clk = ~clk;

  pulse_deconv_disc #(.SAMPLE_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .thr_wr_en(thr_wr_en), .thr_wr_sel(thr_wr_sel), .thr_wr_data(thr_wr_data),
    .amp_out(amp_out), .amp_valid(amp_valid), .flag_hi(flag_hi), .flag_lo(flag_lo));

  function automatic int decay_of(int p);
    return p - (p >> 4);
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare_slot();
    chk({ctx, " R3 R5 valid"}, int'(amp_valid), e_v[2]);
    if (e_v[2] != 0) chk({ctx, " R2 amp"}, int'(amp_out), e_a[2]);
    chk({ctx, " R6 hi"}, int'(flag_hi), e_h[2]);
    chk({ctx, " R7 lo"}, int'(flag_lo), e_l[2]);
  endtask

  task automatic step(bit v, int d);
    int nv, na;
    @(negedge clk);
    compare_slot();
    nv = (v && seen >= 1) ? 1 : 0;
    na = nv ? d - decay_of(prev) : 0;
    for (int i = 2; i > 0; i--) begin
      e_v[i] = e_v[i-1]; e_a[i] = e_a[i-1]; e_h[i] = e_h[i-1]; e_l[i] = e_l[i-1];
    end
    e_v[0] = nv; e_a[0] = na;
    e_h[0] = (nv != 0 && na > thr_hi_m) ? 1 : 0;
    e_l[0] = (nv != 0 && na > thr_lo_m) ? 1 : 0;
    if (v) begin prev = d; seen++; end
    smp_valid = v;
    smp_data  = SW'(d);
  endtask

  task automatic wr_thr(bit sel, int val);
    for (int i = 0; i < 3; i++) step(0, 0);
    @(negedge clk);
    compare_slot();
    for (int i = 2; i > 0; i--) begin
      e_v[i] = e_v[i-1]; e_a[i] = e_a[i-1]; e_h[i] = e_h[i-1]; e_l[i] = e_l[i-1];
    end
    e_v[0] = 0; e_a[0] = 0; e_h[0] = 0; e_l[0] = 0;
    smp_valid = 0;
    thr_wr_en = 1; thr_wr_sel = sel; thr_wr_data = SW'(val);
    @(negedge clk);
    thr_wr_en = 0;
    compare_slot();
    for (int i = 2; i > 0; i--) begin
      e_v[i] = e_v[i-1]; e_a[i] = e_a[i-1]; e_h[i] = e_h[i-1]; e_l[i] = e_l[i-1];
    end
    e_v[0] = 0; e_a[0] = 0; e_h[0] = 0; e_l[0] = 0;
    if (sel) thr_hi_m = val; else thr_lo_m = val;
  endtask

  task automatic do_reset();
    rst_n = 0; smp_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    seen = 0; prev = 0; thr_hi_m = 1023; thr_lo_m = 1023;
    for (int i = 0; i < 3; i++) begin e_v[i] = 0; e_a[i] = 0; e_h[i] = 0; e_l[i] = 0; end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2718);
    for (int i = 0; i < 3; i++) begin e_v[i] = 0; e_a[i] = 0; e_h[i] = 0; e_l[i] = 0; end
    do_reset();

    @(negedge clk);
    chk("R1 valid", int'(amp_valid), 0);
    chk("R1 amp", int'(amp_out), 0);
    chk("R1 hi", int'(flag_hi), 0);
    chk("R1 lo", int'(flag_lo), 0);

    ctx = "R4 R10";
    step(1, 500);
    step(0, 0); step(0, 0); step(0, 0);
    do_reset();
    step(1, 0);
    step(1, 1023);
    step(0, 0); step(0, 0); step(0, 0);

    ctx = "R8 R9";
    wr_thr(1, 0);
    wr_thr(0, 0);
    step(1, 800);
    step(1, 100);
    step(1, 100);
    step(0, 0); step(0, 0); step(0, 0);

    ctx = "R5";
    step(1, 200);
    step(0, 999); step(0, 7); step(0, 512);
    step(1, 300);
    step(0, 0); step(0, 0); step(0, 0);

    ctx = "R6 R7 R9";
    wr_thr(1, 111);
    wr_thr(0, 112);
    step(1, 0);
    step(1, 111);
    step(1, 112 + decay_of(111));
    step(1, 113 + decay_of(112 + decay_of(111)));
    step(0, 0); step(0, 0); step(0, 0);

    ctx = "R2 R3";
    for (int n = 0; n < 3000; n++) begin
      if (n % 500 == 499) begin
        wr_thr(1, int'($urandom_range(0, 400)));
        wr_thr(0, int'($urandom_range(0, 200)));
      end
      step(($urandom_range(0, 3) != 0), int'($urandom_range(0, 1023)));
    end
    step(0, 0); step(0, 0); step(0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule